// File: doc/BRIEF.md
# DRAM ECC Error Log

This block sits beside a memory ECC checker and records error events so that software can inspect them later. Five event strobes come in: correctable (single-bit, with an 8-bit syndrome), uncorrectable (multi-bit), refresh timeout, locked access to non-DRAM space, and thermal event. Each strobe comes with the line address of the failing access (physical address bits 32:7, since addresses are kept at 128-byte granularity) and the channel number. The block sets a sticky status bit for each event type. It keeps one error record (line address, channel, syndrome) and drives a system-error line when an enabled error is pending.

Software works through a byte-addressed register port. Writes take effect at the clock edge and reads are combinational. The status register is cleared by writing 1 to a bit. The command register chooses which error types may raise the system-error line. Three read-only registers present the logged record. An uncorrectable error always takes over the record. A correctable error only writes the record when no status bit is pending. Software that reads status before and after reading the record can therefore tell when a correctable error was replaced by an uncorrectable one.

Top module: `ecc_err_log`

## Requirements
- R1: After reset every register reads zero and `serr_o` is low.
- R2: Each strobe sets its status bit at the next edge, and the bit then holds: correctable at bit 0, uncorrectable at bit 1, refresh timeout at bit 8, non-DRAM lock at bit 9, thermal at bit 11. Status is read at offset 0xC8 in rdata[15:0]. All other status bits read 0.
- R3: A write to offset 0xC8 clears every status bit that has a 1 in wdata. Bits written 0 and the reserved bits are unchanged.
- R4: If a strobe and a clear hit the same status bit in the same cycle, the bit stays set.
- R5: Offset 0x58 reads {line[24:0] (address bits 31:7), six zero bits, channel}. Offset 0x70 reads address bit 32 in bit 0 and zero elsewhere.
- R6: Offset 0x5C reads the logged 8-bit syndrome in bits 7:0 and zero above.
- R7: A correctable strobe without an uncorrectable one writes the record only if the status register read zero before that edge. This includes the case where the only pending bit is not an ECC error.
- R8: An uncorrectable strobe always writes the record, replacing any earlier record. When both ECC strobes arrive together, the record is taken from that same cycle.
- R9: A write to offset 0xCA loads the command register with wdata masked to bits 0, 1, 8, 9 and 11. The value reads back at 0xCA.
- R10: `serr_o` is high exactly when status AND command is nonzero. It follows the registered values, so it changes one edge after a strobe or a write.
- R11: Writes to the record offsets (0x58, 0x5C, 0x70) have no effect. Any offset other than the five listed reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_ce | input | 1 | Correctable ECC error strobe |
| ev_ue | input | 1 | Uncorrectable ECC error strobe |
| ev_rto | input | 1 | Refresh timeout strobe |
| ev_lock | input | 1 | Locked access to non-DRAM strobe |
| ev_therm | input | 1 | Thermal event strobe |
| ev_line | input | 26 | Failing physical address bits 32:7 |
| ev_chan | input | 1 | Failing channel |
| ev_syn | input | 8 | ECC syndrome of the event |
| reg_wr | input | 1 | Register write enable |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr |
| serr_o | output | 1 | System-error output |

## Verification
The bench targets several corner cases:
- A correctable error that arrives while only a non-ECC bit is pending, or while an uncorrectable record is held. A design that gates capture on the ECC bits alone, or always captures, would show the wrong address and syndrome.
- A clear that arrives in the same cycle as a new event on the same bit. If clear won, the event would be lost.
- Partial clears and writes with reserved bits set. Wrong masking would leave bits set or make reserved bits appear.
- Every pairing of command and status patterns, checked against `serr_o`. An inverted or unmasked enable shows up there.
- Writes to the read-only record offsets, and reads of unmapped offsets. These show any decoding that aliases offsets.

// File: rtl/ecc_log_pkg.sv
`timescale 1ns/1ps
package ecc_log_pkg;
    localparam int PA_W      = 33;
    localparam int GRAIN_LSB = 7;
    localparam int LINE_W    = PA_W - GRAIN_LSB;
    localparam int SYN_W     = 8;
    localparam int RA_W      = 8;
    localparam int REG_W     = 16;
    localparam int RD_W      = 32;

    localparam int BIT_CE    = 0;
    localparam int BIT_UE    = 1;
    localparam int BIT_RTO   = 8;
    localparam int BIT_LOCK  = 9;
    localparam int BIT_THERM = 11;

    localparam logic [REG_W-1:0] ERR_MASK = (REG_W'(1) << BIT_CE) | (REG_W'(1) << BIT_UE)
                                          | (REG_W'(1) << BIT_RTO) | (REG_W'(1) << BIT_LOCK)
                                          | (REG_W'(1) << BIT_THERM);

    localparam logic [RA_W-1:0] OFF_ADDR  = 8'h58;
    localparam logic [RA_W-1:0] OFF_SYN   = 8'h5C;
    localparam logic [RA_W-1:0] OFF_XADDR = 8'h70;
    localparam logic [RA_W-1:0] OFF_STS   = 8'hC8;
    localparam logic [RA_W-1:0] OFF_CMD   = 8'hCA;

    typedef struct packed {
        logic [LINE_W-1:0] line;
        logic              chan;
        logic [SYN_W-1:0]  syn;
    } err_rec_t;

    typedef struct packed {
        logic [REG_W-1:0] sts;
        logic [REG_W-1:0] cmd;
    } ctl_state_t;
endpackage

// File: rtl/ecc_log_status.sv
`timescale 1ns/1ps
module ecc_log_status
    import ecc_log_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [REG_W-1:0] set_i,
    input  logic             sts_wr_i,
    input  logic             cmd_wr_i,
    input  logic [REG_W-1:0] wdata_i,
    output logic [REG_W-1:0] sts_o,
    output logic [REG_W-1:0] cmd_o,
    output logic             serr_o
);
    ctl_state_t       st_d, st_q;
    logic [REG_W-1:0] clr_v;

    always_comb begin
        st_d  = st_q;
        clr_v = sts_wr_i ? (wdata_i & ERR_MASK) : '0;
        // a new event beats a clear on the same bit
        st_d.sts = ((st_q.sts & ~clr_v) | set_i) & ERR_MASK;
        if (cmd_wr_i) begin
            st_d.cmd = wdata_i & ERR_MASK;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sts_o  = st_q.sts;
    assign cmd_o  = st_q.cmd;
    assign serr_o = |(st_q.sts & st_q.cmd);

    // R2 and R4: a strobed bit is set after the edge, whatever the clear did
    a_r2_event_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (set_i != '0) |=> ((st_q.sts & $past(set_i)) == $past(set_i)));

    // R3: a cleared bit with no new event reads zero afterwards
    a_r3_clear_takes: assert property (@(posedge clk) disable iff (!rst_n)
        ((clr_v & ~set_i) != '0) |=> ((st_q.sts & $past(clr_v & ~set_i)) == '0));

    // R3: no event and no status write leaves status untouched
    a_r3_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!sts_wr_i && set_i == '0) |=> $stable(st_q.sts));
endmodule

// File: rtl/ecc_log_capture.sv
`timescale 1ns/1ps
module ecc_log_capture
    import ecc_log_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_i,
    input  logic              ue_i,
    input  logic              pending_i,
    input  logic [LINE_W-1:0] line_i,
    input  logic              chan_i,
    input  logic [SYN_W-1:0]  syn_i,
    output err_rec_t          rec_o
);
    err_rec_t rec_d, rec_q;
    logic     take;

    always_comb begin
        rec_d = rec_q;
        take  = ue_i || (ce_i && !pending_i);
        if (take) begin
            rec_d.line = line_i;
            rec_d.chan = chan_i;
            rec_d.syn  = syn_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rec_q <= '0;
        end else begin
            rec_q <= rec_d;
        end
    end

    assign rec_o = rec_q;

    // R7: a correctable event while anything is pending keeps the record
    a_r7_ce_blocked: assert property (@(posedge clk) disable iff (!rst_n)
        (ce_i && !ue_i && pending_i) |=> $stable(rec_q));

    // R8: an uncorrectable event always lands in the record
    a_r8_ue_takes: assert property (@(posedge clk) disable iff (!rst_n)
        ue_i |=> (rec_q.syn == $past(syn_i) && rec_q.line == $past(line_i)
                  && rec_q.chan == $past(chan_i)));
endmodule

// File: rtl/ecc_log_regmux.sv
`timescale 1ns/1ps
module ecc_log_regmux
    import ecc_log_pkg::*;
(
    input  logic [RA_W-1:0]  addr_i,
    input  logic [REG_W-1:0] sts_i,
    input  logic [REG_W-1:0] cmd_i,
    input  err_rec_t         rec_i,
    output logic [RD_W-1:0]  rdata_o
);
    localparam int PAD_LO = GRAIN_LSB - 1;

    always_comb begin
        unique case (addr_i)
            OFF_ADDR:  rdata_o = {rec_i.line[LINE_W-2:0], {PAD_LO{1'b0}}, rec_i.chan};
            OFF_XADDR: rdata_o = {{(RD_W-1){1'b0}}, rec_i.line[LINE_W-1]};
            OFF_SYN:   rdata_o = {{(RD_W-SYN_W){1'b0}}, rec_i.syn};
            OFF_STS:   rdata_o = {{(RD_W-REG_W){1'b0}}, sts_i};
            OFF_CMD:   rdata_o = {{(RD_W-REG_W){1'b0}}, cmd_i};
            default:   rdata_o = '0;
        endcase
    end
endmodule

// File: rtl/ecc_err_log.sv
`timescale 1ns/1ps
module ecc_err_log
    import ecc_log_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ev_ce,
    input  logic              ev_ue,
    input  logic              ev_rto,
    input  logic              ev_lock,
    input  logic              ev_therm,
    input  logic [LINE_W-1:0] ev_line,
    input  logic              ev_chan,
    input  logic [SYN_W-1:0]  ev_syn,
    input  logic              reg_wr,
    input  logic [RA_W-1:0]   reg_addr,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [RD_W-1:0]   reg_rdata,
    output logic              serr_o
);
    logic [REG_W-1:0] set_v;
    logic [REG_W-1:0] sts_w, cmd_w;
    logic             sts_wr, cmd_wr;
    err_rec_t         rec_w;

    always_comb begin
        set_v            = '0;
        set_v[BIT_CE]    = ev_ce;
        set_v[BIT_UE]    = ev_ue;
        set_v[BIT_RTO]   = ev_rto;
        set_v[BIT_LOCK]  = ev_lock;
        set_v[BIT_THERM] = ev_therm;
        sts_wr           = reg_wr && (reg_addr == OFF_STS);
        cmd_wr           = reg_wr && (reg_addr == OFF_CMD);
    end

    ecc_log_status u_status (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_i    (set_v),
        .sts_wr_i (sts_wr),
        .cmd_wr_i (cmd_wr),
        .wdata_i  (reg_wdata),
        .sts_o    (sts_w),
        .cmd_o    (cmd_w),
        .serr_o   (serr_o)
    );

    ecc_log_capture u_capture (
        .clk       (clk),
        .rst_n     (rst_n),
        .ce_i      (ev_ce),
        .ue_i      (ev_ue),
        .pending_i (sts_w != '0),
        .line_i    (ev_line),
        .chan_i    (ev_chan),
        .syn_i     (ev_syn),
        .rec_o     (rec_w)
    );

    ecc_log_regmux u_regmux (
        .addr_i  (reg_addr),
        .sts_i   (sts_w),
        .cmd_i   (cmd_w),
        .rec_i   (rec_w),
        .rdata_o (reg_rdata)
    );

    // R10: the error line needs both an enable and a pending error
    a_r10_serr_gated: assert property (@(posedge clk) disable iff (!rst_n)
        serr_o |-> (cmd_w != '0 && sts_w != '0));

    // R11: a write to the syndrome offset leaves the syndrome readout alone
    a_r11_syn_readonly: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == OFF_SYN && !ev_ce && !ev_ue) |=> $stable(rec_w.syn));
endmodule

// File: tb/ecc_err_log_tb.sv
`timescale 1ns/1ps
module ecc_err_log_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ev_ce = 0, ev_ue = 0, ev_rto = 0, ev_lock = 0, ev_therm = 0;
    logic [25:0] ev_line = '0;
    logic        ev_chan = 1'b0;
    logic [7:0]  ev_syn = '0;
    logic        reg_wr = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [15:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        serr_o;

    int errs = 0;
    int checks = 0;
    bit done = 0;

    logic [15:0] m_sts = '0, m_cmd = '0;
    logic [25:0] m_line = '0;
    logic        m_chan = 1'b0;
    logic [7:0]  m_syn = '0;

    always #4 clk = ~clk;

    ecc_err_log u_dut (
        .clk(clk), .rst_n(rst_n),
        .ev_ce(ev_ce), .ev_ue(ev_ue), .ev_rto(ev_rto), .ev_lock(ev_lock), .ev_therm(ev_therm),
        .ev_line(ev_line), .ev_chan(ev_chan), .ev_syn(ev_syn),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .serr_o(serr_o)
    );

    function automatic logic [15:0] evmap(input logic [4:0] e);
        return {4'b0, e[4], 1'b0, e[3], e[2], 6'b0, e[1], e[0]};
    endfunction

    task automatic chk(input string req, input string what, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errs++;
            $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
        end
    endtask

    task automatic rd(input string req, input logic [7:0] a, input logic [31:0] exp);
        reg_addr = a;
        #1;
        chk(req, $sformatf("offset %h", a), reg_rdata, exp);
    endtask

    // full register image vs model; runs in the 8 ns gap after an edge
    task automatic check_all(input string req);
        rd(req, 8'h58, {m_line[24:0], 6'b0, m_chan});
        rd(req, 8'h70, {31'b0, m_line[25]});
        rd(req, 8'h5C, {24'b0, m_syn});
        rd(req, 8'hC8, {16'b0, m_sts});
        rd(req, 8'hCA, {16'b0, m_cmd});
        chk(req, "serr", {31'b0, serr_o}, {31'b0, |(m_sts & m_cmd)});
    endtask

    task automatic cyc(input logic [4:0] ev, input logic [25:0] ln, input logic ch,
                       input logic [7:0] sy, input logic wr, input logic [7:0] wa,
                       input logic [15:0] wd);
        logic pend;
        {ev_therm, ev_lock, ev_rto, ev_ue, ev_ce} = ev;
        ev_line = ln; ev_chan = ch; ev_syn = sy;
        reg_wr = wr; reg_addr = wa; reg_wdata = wd;
        pend = (m_sts != 16'h0);
        @(posedge clk);
        #1;
        {ev_therm, ev_lock, ev_rto, ev_ue, ev_ce} = '0;
        reg_wr = 1'b0;
        if (wr && wa == 8'hC8) m_sts = m_sts & ~(wd & 16'h0B03);
        m_sts = m_sts | evmap(ev);
        if (wr && wa == 8'hCA) m_cmd = wd & 16'h0B03;
        if (ev[1] || (ev[0] && !pend)) begin
            m_line = ln; m_chan = ch; m_syn = sy;
        end
    endtask

    task automatic clear_all();
        cyc(5'b0, '0, 1'b0, '0, 1'b1, 8'hC8, 16'hFFFF);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        check_all("R1");

        // R2/R3: each event type on its own, then cleared
        for (int k = 0; k < 5; k++) begin
            cyc(5'(1 << k), 26'h3000000 + 26'(k), k[0], 8'(8'h11 * k), 1'b0, 8'h00, 16'h0);
            check_all("R2");
            clear_all();
            check_all("R3");
        end

        // R2/R5/R6/R8/R3: every event combination, then a partial clear
        for (int m = 1; m < 32; m++) begin
            logic [25:0] ln;
            ln = {m[0], 25'h0AAAAAA ^ 25'(m * 977)};
            cyc(5'(m), ln, m[1], 8'(m * 37), 1'b0, 8'h00, 16'h0);
            check_all("R2 R5 R6 R8");
            cyc(5'b0, '0, 1'b0, '0, 1'b1, 8'hC8, evmap(5'(m * 7)) | 16'hF4FC);
            check_all("R3");
            clear_all();
        end

        // R7 / R8 ordering
        cyc(5'b00001, 26'h1234567, 1'b1, 8'hA5, 1'b0, 8'h0, 16'h0);
        check_all("R7 first CE logged");
        cyc(5'b00001, 26'h0ABCDEF, 1'b0, 8'h5A, 1'b0, 8'h0, 16'h0);
        check_all("R7 second CE held off");
        cyc(5'b00010, 26'h2FEDCBA, 1'b0, 8'hC3, 1'b0, 8'h0, 16'h0);
        check_all("R8 UE overwrote CE");
        cyc(5'b00001, 26'h0111111, 1'b1, 8'h3C, 1'b0, 8'h0, 16'h0);
        check_all("R7 CE after UE held off");
        cyc(5'b00010, 26'h0222222, 1'b1, 8'h99, 1'b0, 8'h0, 16'h0);
        check_all("R8 UE over UE");
        clear_all();
        cyc(5'b00100, 26'h0, 1'b0, 8'h0, 1'b0, 8'h0, 16'h0);
        cyc(5'b00001, 26'h0333333, 1'b1, 8'h77, 1'b0, 8'h0, 16'h0);
        check_all("R7 CE blocked by timeout bit");
        clear_all();
        // CE in the cycle that clears everything: pending still seen
        cyc(5'b00010, 26'h0444444, 1'b0, 8'h44, 1'b0, 8'h0, 16'h0);
        cyc(5'b00001, 26'h0555555, 1'b1, 8'h55, 1'b1, 8'hC8, 16'hFFFF);
        check_all("R7 CE with clear");
        clear_all();

        // R4: event and clear on the same bit
        for (int k = 0; k < 5; k++) begin
            cyc(5'(1 << k), 26'h0, 1'b0, 8'h0, 1'b0, 8'h0, 16'h0);
            cyc(5'(1 << k), 26'h0, 1'b0, 8'h0, 1'b1, 8'hC8, 16'hFFFF);
            check_all("R4");
            clear_all();
        end

        // R9: command write sweep, reserved bits forced high
        for (int c = 0; c < 32; c++) begin
            cyc(5'b0, '0, 1'b0, '0, 1'b1, 8'hCA, evmap(5'(c)) | 16'hF4FC);
            check_all("R9");
        end

        // R10: every command against every status pattern
        for (int c = 0; c < 32; c++) begin
            for (int s = 0; s < 32; s++) begin
                cyc(5'b0, '0, 1'b0, '0, 1'b1, 8'hCA, evmap(5'(c)));
                cyc(5'(s), 26'(s), 1'b0, 8'(s), 1'b0, 8'h0, 16'h0);
                checks++;
                if (serr_o !== |(evmap(5'(c)) & evmap(5'(s)))) begin
                    errs++;
                    $display("FAIL R10 serr cmd=%0d sts=%0d: got %b expected %b",
                             c, s, serr_o, |(evmap(5'(c)) & evmap(5'(s))));
                end
                clear_all();
                checks++;
                if (serr_o !== 1'b0) begin
                    errs++;
                    $display("FAIL R10 serr after clear: got %b expected 0", serr_o);
                end
            end
        end

        // R11: record offsets read-only, unmapped offsets read zero
        cyc(5'b00010, 26'h1357913, 1'b1, 8'hE7, 1'b0, 8'h0, 16'h0);
        cyc(5'b0, '0, 1'b0, '0, 1'b1, 8'h58, 16'hFFFF);
        cyc(5'b0, '0, 1'b0, '0, 1'b1, 8'h5C, 16'h0000);
        cyc(5'b0, '0, 1'b0, '0, 1'b1, 8'h70, 16'h0000);
        check_all("R11 read-only");
        rd("R11", 8'h00, 32'h0);
        rd("R11", 8'h59, 32'h0);
        rd("R11", 8'hC9, 32'h0);
        rd("R11", 8'hCB, 32'h0);
        rd("R11", 8'hFF, 32'h0);

        // R1: reset again returns everything to zero
        rst_n = 1'b0;
        @(posedge clk);
        #1 rst_n = 1'b1;
        m_sts = '0; m_cmd = '0; m_line = '0; m_chan = 1'b0; m_syn = '0;
        check_all("R1 second reset");

        done = 1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            errs++;
            checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end
endmodule